// File: doc/BRIEF.md
# Masked Alarm Comparator with Interrupt and Frequency-Test Output

This block watches a running BCD calendar (date, hours, minutes, seconds) and raises an alarm when it agrees with four programmable alarm registers. Each alarm register carries an ignore bit in its most significant position that drops that field from the comparison. The ignore bits taken together choose how often the alarm repeats: monthly, daily, hourly, every minute or every second. A setting that is not one of these five is treated as every second. A match is only evaluated on a one-hertz tick. It sets an alarm flag and, if enabled, pulls an active-low open-drain interrupt pin. While the system runs from its backup supply, a second enable must also be set before the pin is driven.

The flag register reports the alarm flag next to two status bits supplied from outside. Any read or write of it releases the interrupt as soon as the access starts. The flag itself only clears once the access has ended, so the access still reads it as set. Both enables drop whenever the supply source changes. The flag survives that change, so software can see an alarm that happened during the changeover. When the pin is not used for the alarm, it can instead carry a 512 Hz square wave derived from the 32.768 kHz oscillator enable, so the oscillator frequency can be measured. The time counter, the watchdog and the supply monitor are outside this block and only provide inputs to it.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset the alarm flag, interrupt pending state, alarm enable, backup enable and frequency-test bit are all 0, all alarm registers read 0x00, and the pin is released (`irq_pull` = 0).
- R2: Offsets 2, 3, 4 and 5 hold the seconds, minutes, hours and date alarm registers (8 bits, read back as written). Offset 6 holds the alarm enable in bit 7, the backup enable in bit 6 and the frequency-test bit in bit 0, and its other bits read 0. Every other offset except 0 reads 0x00 and ignores writes.
- R3: Offset 0 is read-only. Bit 7 reports `wdog_flag`, bit 6 the alarm flag and bit 4 `batt_low`. Bits 5 and 3..0 read 0, and a write to it changes no state except the clearing in R8.
- R4: The ignore bits are bit 7 of offsets 2, 3, 4 and 5. Written as {date, hour, min, sec}, 0000 matches date+hour+min+sec, 1000 matches hour+min+sec, 1100 matches min+sec, 1110 matches sec, and 1111 matches every tick. Seconds and minutes compare 7 bits, hours and date compare 6 bits.
- R5: Any other combination of ignore bits behaves as 1111 (alarm on every tick).
- R6: The alarm flag is set at the clock edge where `tick_1hz` is 1 and the fields match. A matching time without a tick never sets it.
- R7: A match tick sets the interrupt pending state (pin pulled low) only if the alarm enable is 1 on main power, or if both alarm enable and backup enable are 1 while `on_battery` = 1.
- R8: The first cycle of any access (`bus_en` = 1) to offset 0 clears the interrupt pending state, so the pin is released one cycle later. The alarm flag stays 1 throughout the access and clears at the first edge where the access is no longer present. A match tick at that same edge keeps the flag set.
- R9: Any change of `on_battery` clears the alarm enable and the backup enable and releases a pending interrupt. The alarm flag is kept.
- R10: When `osc_run` = 1, frequency-test = 1, alarm enable = 0, and either `wdog_steer` = 1 or `wdog_zero` = 1, the pin toggles after every 32 `osc_tick` pulses (512 Hz from 32.768 kHz), starting released. Otherwise the test output is off and its divider restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse once per second; the alarm is evaluated only then |
| osc_tick | input | 1 | One-cycle enable at the 32.768 kHz oscillator rate |
| osc_run | input | 1 | Oscillator is running |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| on_battery | input | 1 | System runs from the backup supply |
| wdog_steer | input | 1 | Watchdog routes its timeout to the reset output |
| wdog_zero | input | 1 | Watchdog register holds zero (watchdog off) |
| wdog_flag | input | 1 | Watchdog flag, reported in the flag register |
| batt_low | input | 1 | Low-battery indication, reported in the flag register |
| bus_en | input | 1 | Register access active, held for the whole access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt / test pin low |

## Verification
On every cycle the assertions check the following. The flag is set after each matching tick and cannot rise without a tick. It cannot fall while a flag access is still in progress. The interrupt is only raised with the right enables for the present supply. A supply change clears both enables. The test divider changes level only on an oscillator enable and rests low when it is off. The bench's scenarios must show the rest: the five repeat rates, the fallback for invalid ignore-bit patterns, the read-back layout of each register, and the 512 Hz rate with its gating by the watchdog steering and the alarm enable. They also cover the ordering when a flag access ends on the same edge as a matching tick.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NFIELD       = 4;
  localparam int OFF_FLAG     = 0;
  localparam int OFF_ALM_BASE = 2;
  localparam int OFF_CTRL     = 6;
  localparam int CTL_AE       = 7;
  localparam int CTL_ABE      = 6;
  localparam int CTL_FT       = 0;
  localparam int FLG_WF       = 7;
  localparam int FLG_AF       = 6;
  localparam int FLG_BLOW     = 4;

  typedef enum logic [1:0] {FLD_SEC, FLD_MIN, FLD_HOUR, FLD_DATE} field_e;

  // Compared width of each BCD field.
  function automatic int field_width(input int idx);
    return (idx == int'(FLD_SEC) || idx == int'(FLD_MIN)) ? 7 : 6;
  endfunction

  // Ignore bits {date,hour,min,sec}; a legal pattern ignores a contiguous
  // run from the date downward. Anything else ignores everything.
  function automatic logic [3:0] eff_ignore(input logic [3:0] ign);
    logic legal;
    legal = (ign == 4'b0000) || (ign == 4'b1000) || (ign == 4'b1100) ||
            (ign == 4'b1110) || (ign == 4'b1111);
    return legal ? ign : 4'b1111;
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic                      bus_en,
  input  logic                      bus_we,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  input  logic                      pwr_change,
  input  logic                      wf_in,
  input  logic                      blow_in,
  input  logic                      af_in,
  output logic [NFIELD-1:0][DW-1:0] alm_q,
  output logic                      ae_q,
  output logic                      abe_q,
  output logic                      ft_q,
  output logic [DW-1:0]             bus_rdata
);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_FLAG = AW'(OFF_FLAG);

  logic                      wr_stb;
  logic [NFIELD-1:0][DW-1:0] alm_d;
  logic                      ae_d, abe_d, ft_d;

  assign wr_stb = bus_en & bus_we;

  for (genvar i = 0; i < NFIELD; i++) begin : g_alm
    localparam logic [AW-1:0] A_MINE = AW'(OFF_ALM_BASE + i);
    always_comb begin
      alm_d[i] = alm_q[i];
      if (wr_stb && bus_addr == A_MINE) alm_d[i] = bus_wdata;
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) alm_q[i] <= '0;
      else         alm_q[i] <= alm_d[i];
    end
  end

  always_comb begin
    ae_d  = ae_q;
    abe_d = abe_q;
    ft_d  = ft_q;
    if (wr_stb && bus_addr == A_CTRL) begin
      ae_d  = bus_wdata[CTL_AE];
      abe_d = bus_wdata[CTL_ABE];
      ft_d  = bus_wdata[CTL_FT];
    end
    if (pwr_change) begin
      ae_d  = 1'b0;
      abe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q  <= 1'b0;
      abe_q <= 1'b0;
      ft_q  <= 1'b0;
    end else begin
      ae_q  <= ae_d;
      abe_q <= abe_d;
      ft_q  <= ft_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_FLAG) begin
      bus_rdata[FLG_WF]   = wf_in;
      bus_rdata[FLG_AF]   = af_in;
      bus_rdata[FLG_BLOW] = blow_in;
    end else if (bus_addr == A_CTRL) begin
      bus_rdata[CTL_AE]  = ae_q;
      bus_rdata[CTL_ABE] = abe_q;
      bus_rdata[CTL_FT]  = ft_q;
    end else begin
      for (int k = 0; k < NFIELD; k++)
        if (bus_addr == AW'(OFF_ALM_BASE + k)) bus_rdata = alm_q[k];
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NFIELD-1:0][DW-1:0] cur,
  input  logic [NFIELD-1:0][DW-1:0] alm,
  output logic                      hit
);
  localparam int IGN_BIT = DW - 1;

  logic [NFIELD-1:0] eq;
  logic [NFIELD-1:0] ign;
  logic [NFIELD-1:0] ign_eff;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam int FW = field_width(i);
    assign eq[i]  = (cur[i][FW-1:0] == alm[i][FW-1:0]);
    assign ign[i] = alm[i][IGN_BIT];
  end

  assign ign_eff = eff_ignore(ign);
  assign hit     = &(eq | ign_eff);
endmodule

// File: rtl/alarm_flags.sv
module alarm_flags (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick,
  input  logic hit,
  input  logic irq_en,
  input  logic flag_acc,
  input  logic pwr_change,
  output logic acc_q,
  output logic af_q,
  output logic pend_q
);
  logic acc_start, acc_end, fire;
  logic af_d, pend_d;

  assign fire      = tick & hit;
  assign acc_start = flag_acc & ~acc_q;
  assign acc_end   = acc_q & ~flag_acc;

  always_comb begin
    af_d = af_q;
    if (fire)         af_d = 1'b1;
    else if (acc_end) af_d = 1'b0;
  end

  always_comb begin
    pend_d = pend_q;
    if (fire && irq_en)               pend_d = 1'b1;
    else if (acc_start || pwr_change) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= 1'b0;
      af_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      acc_q  <= flag_acc;
      af_q   <= af_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/ft_divider.sv
module ft_divider #(
  parameter int OSC_HZ = 32768,
  parameter int FT_HZ  = 512
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic run,
  input  logic osc_tick,
  output logic lvl_q
);
  localparam int HALF = OSC_HZ / (2 * FT_HZ);
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!run) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (osc_tick) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        lvl_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int OSC_HZ = 32768,
  parameter int FT_HZ  = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          osc_tick,
  input  logic          osc_run,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_date,
  input  logic          on_battery,
  input  logic          wdog_steer,
  input  logic          wdog_zero,
  input  logic          wdog_flag,
  input  logic          batt_low,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_pull
);
  logic [1:0]                rs_q;
  logic                      rst_ni;
  logic                      batt_q;
  logic                      pwr_change;
  logic                      flag_acc;
  logic [NFIELD-1:0][DW-1:0] cur_f;
  logic [NFIELD-1:0][DW-1:0] alm_q;
  logic                      ae_q, abe_q, ft_q;
  logic                      hit, irq_en;
  logic                      acc_q, af_q, pend_q;
  logic                      ft_run, ft_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) batt_q <= 1'b0;
    else         batt_q <= on_battery;
  end

  assign pwr_change = on_battery ^ batt_q;
  assign flag_acc   = bus_en & (bus_addr == AW'(OFF_FLAG));
  assign cur_f      = {cur_date, cur_hour, cur_min, cur_sec};
  assign irq_en     = on_battery ? (ae_q & abe_q) : ae_q;
  assign ft_run     = osc_run & ft_q & ~ae_q & (wdog_steer | wdog_zero);
  assign irq_pull   = pend_q | (ft_run & ft_lvl);

  alarm_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pwr_change(pwr_change),
    .wf_in(wdog_flag), .blow_in(batt_low), .af_in(af_q), .alm_q(alm_q),
    .ae_q(ae_q), .abe_q(abe_q), .ft_q(ft_q), .bus_rdata(bus_rdata)
  );

  alarm_match #(.DW(DW)) u_match (
    .cur(cur_f), .alm(alm_q), .hit(hit)
  );

  alarm_flags u_flags (
    .clk(clk), .rst_ni(rst_ni), .tick(tick_1hz), .hit(hit), .irq_en(irq_en),
    .flag_acc(flag_acc), .pwr_change(pwr_change), .acc_q(acc_q),
    .af_q(af_q), .pend_q(pend_q)
  );

  ft_divider #(.OSC_HZ(OSC_HZ), .FT_HZ(FT_HZ)) u_ft (
    .clk(clk), .rst_ni(rst_ni), .run(ft_run), .osc_tick(osc_tick),
    .lvl_q(ft_lvl)
  );
endmodule

// File: rtl/alarm_irq_unit_chk.sv
module alarm_irq_unit_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          tick_1hz,
  input logic          hit,
  input logic          af_q,
  input logic          pend_q,
  input logic          ae_q,
  input logic          abe_q,
  input logic          on_battery,
  input logic          batt_q,
  input logic          flag_acc,
  input logic          ft_run,
  input logic          ft_lvl,
  input logic          osc_tick,
  input logic          bus_en,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata
);
  AST_FLAG_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_en && !bus_we && bus_addr == '0) |-> (bus_rdata[5] == 1'b0 && bus_rdata[3:0] == 4'h0)); // R3

  AST_AF_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_1hz && hit) |=> af_q); // R6

  AST_AF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    (!af_q && !tick_1hz) |=> !af_q); // R6

  AST_IRQ_NEEDS_AE: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(ae_q)); // R7

  AST_IRQ_BATT_NEEDS_ABE: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(pend_q) && $past(on_battery)) |-> $past(abe_q)); // R7

  AST_AF_HELD_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_acc && af_q) |=> af_q); // R8

  AST_PWR_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_ni)
    (on_battery != batt_q) |=> (!ae_q && !abe_q)); // R9

  AST_FT_STEP_ON_OSC: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(ft_run) && !$stable(ft_lvl)) |-> $past(osc_tick)); // R10

  AST_FT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    !ft_run |=> !ft_lvl); // R10
endmodule

bind alarm_irq_unit alarm_irq_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .tick_1hz(tick_1hz), .hit(hit), .af_q(af_q),
  .pend_q(pend_q), .ae_q(ae_q), .abe_q(abe_q), .on_battery(on_battery),
  .batt_q(batt_q), .flag_acc(flag_acc), .ft_run(ft_run), .ft_lvl(ft_lvl),
  .osc_tick(osc_tick), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/alarm_irq_unit_bench.sv
module alarm_irq_unit_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tick_1hz = 0, osc_tick = 0, osc_run = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 0;
  logic       on_battery = 0, wdog_steer = 0, wdog_zero = 0, wdog_flag = 0, batt_low = 0;
  logic       bus_en = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       irq_pull;

  alarm_irq_unit u_alarm_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_tick(osc_tick),
    .osc_run(osc_run), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .on_battery(on_battery), .wdog_steer(wdog_steer),
    .wdog_zero(wdog_zero), .wdog_flag(wdog_flag), .batt_low(batt_low),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_pull(irq_pull)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_alm [4];
  bit m_ae, m_abe, m_ft, m_af, m_pend, m_acc_prev, m_batt_prev, m_lvl;
  int m_cnt, sync_cnt;

  function automatic bit m_match();
    bit s, mi, h, d;
    s  = cur_sec[6:0]  == m_alm[0][6:0];
    mi = cur_min[6:0]  == m_alm[1][6:0];
    h  = cur_hour[5:0] == m_alm[2][5:0];
    d  = cur_date[5:0] == m_alm[3][5:0];
    case ({m_alm[3][7], m_alm[2][7], m_alm[1][7], m_alm[0][7]})
      4'b0000: return d & h & mi & s;
      4'b1000: return h & mi & s;
      4'b1100: return mi & s;
      4'b1110: return s;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit m_ftrun();
    return osc_run && m_ft && !m_ae && (wdog_steer || wdog_zero);
  endfunction

  function automatic logic [7:0] exp_rdata();
    case (bus_addr)
      4'd0: return {wdog_flag, m_af, 1'b0, batt_low, 4'b0};
      4'd2, 4'd3, 4'd4, 4'd5: return m_alm[bus_addr - 4'd2];
      4'd6: return {m_ae, m_abe, 5'b0, m_ft};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_alm[i]) m_alm[i] = 8'h00;
      m_ae = 0; m_abe = 0; m_ft = 0; m_af = 0; m_pend = 0;
      m_acc_prev = 0; m_batt_prev = 0; m_lvl = 0; m_cnt = 0; sync_cnt = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else begin
      bit hit, acc, pchg, en, run;
      hit  = tick_1hz && m_match();
      acc  = bus_en && bus_addr == 4'd0;
      pchg = on_battery != m_batt_prev;
      en   = on_battery ? (m_ae && m_abe) : m_ae;
      run  = m_ftrun();
      if (hit) m_af = 1; else if (m_acc_prev && !acc) m_af = 0;
      if (hit && en) m_pend = 1; else if ((acc && !m_acc_prev) || pchg) m_pend = 0;
      if (bus_en && bus_we) begin
        if (bus_addr >= 4'd2 && bus_addr <= 4'd5) m_alm[bus_addr - 4'd2] = bus_wdata;
        if (bus_addr == 4'd6) begin
          m_ae = bus_wdata[7]; m_abe = bus_wdata[6]; m_ft = bus_wdata[0];
        end
      end
      if (pchg) begin m_ae = 0; m_abe = 0; end
      if (!run) begin m_cnt = 0; m_lvl = 0; end
      else if (osc_tick) begin
        if (m_cnt == 31) begin m_cnt = 0; m_lvl = !m_lvl; end
        else m_cnt++;
      end
      m_acc_prev  = acc;
      m_batt_prev = on_battery;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "pin vs model", irq_pull, m_pend | (m_ftrun() & m_lvl));
      if (bus_en && !bus_we) chk(cur_req, "rdata vs model", bus_rdata, exp_rdata());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    step(); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    step(); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); v = bus_rdata;
    step(); bus_en = 0;
  endtask

  task automatic tick_at(input logic [7:0] d, h, m, s);
    step(); cur_date = d; cur_hour = h; cur_min = m; cur_sec = s; tick_1hz = 1;
    step(); tick_1hz = 0;
  endtask

  task automatic set_ignore(input logic [3:0] n);
    wr(4'd2, {n[0], 7'h56}); wr(4'd3, {n[1], 7'h34});
    wr(4'd4, {n[2], 7'h12}); wr(4'd5, {n[3], 7'h15});
  endtask

  task automatic mode_case(string req, input logic [3:0] n,
                           input logic [7:0] d, h, m, s, input bit exp);
    logic [7:0] v;
    cur_req = req;
    set_ignore(n);
    tick_at(d, h, m, s);
    @(negedge clk); chk(req, "pin after tick", irq_pull, exp);
    rd(4'd0, v); chk(req, "alarm flag", v[6], exp);
  endtask

  task automatic count_toggles(input int n, output int t);
    logic prev;
    t = 0;
    @(negedge clk); prev = irq_pull;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_pull !== prev) t++;
      prev = irq_pull;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0] v;
    int t;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) step();

    // R1: reset state
    cur_req = "R1";
    chk("R1", "pin released", irq_pull, 1'b0);
    rd(4'd0, v); chk("R1", "flag reg", v, 8'h00);
    for (int a = 2; a <= 6; a++) begin
      rd(4'(a), v); chk("R1", "reg after reset", v, 8'h00);
    end

    // R2: register map
    cur_req = "R2";
    wr(4'd2, 8'hA5); wr(4'd3, 8'h5A); wr(4'd4, 8'hC3); wr(4'd5, 8'h3C);
    rd(4'd2, v); chk("R2", "sec alarm", v, 8'hA5);
    rd(4'd3, v); chk("R2", "min alarm", v, 8'h5A);
    rd(4'd4, v); chk("R2", "hour alarm", v, 8'hC3);
    rd(4'd5, v); chk("R2", "date alarm", v, 8'h3C);
    wr(4'd6, 8'hFF); rd(4'd6, v); chk("R2", "ctrl layout", v, 8'hC1);
    wr(4'd6, 8'h00);
    wr(4'd1, 8'hFF); rd(4'd1, v); chk("R2", "unused offset 1", v, 8'h00);
    wr(4'd7, 8'hFF); rd(4'd7, v); chk("R2", "unused offset 7", v, 8'h00);

    // R3: flag register
    cur_req = "R3";
    wdog_flag = 1; batt_low = 1;
    rd(4'd0, v); chk("R3", "flag status bits", v, 8'h90);
    wr(4'd0, 8'hFF); rd(4'd0, v); chk("R3", "flag after write", v, 8'h90);
    wdog_flag = 0; batt_low = 0;

    // R4 / R5: repeat rates
    wr(4'd6, 8'h80);
    mode_case("R4", 4'b0000, 8'h15, 8'h12, 8'h34, 8'h56, 1);
    mode_case("R4", 4'b0000, 8'h16, 8'h12, 8'h34, 8'h56, 0);
    mode_case("R4", 4'b1000, 8'h16, 8'h12, 8'h34, 8'h56, 1);
    mode_case("R4", 4'b1000, 8'h16, 8'h13, 8'h34, 8'h56, 0);
    mode_case("R4", 4'b1100, 8'h16, 8'h13, 8'h34, 8'h56, 1);
    mode_case("R4", 4'b1100, 8'h16, 8'h13, 8'h35, 8'h56, 0);
    mode_case("R4", 4'b1110, 8'h16, 8'h13, 8'h35, 8'h56, 1);
    mode_case("R4", 4'b1110, 8'h16, 8'h13, 8'h35, 8'h57, 0);
    mode_case("R4", 4'b1111, 8'h01, 8'h02, 8'h03, 8'h04, 1);
    mode_case("R5", 4'b0101, 8'h01, 8'h02, 8'h03, 8'h04, 1);
    mode_case("R5", 4'b0001, 8'h01, 8'h02, 8'h03, 8'h04, 1);

    // R6: matching time without tick
    cur_req = "R6";
    set_ignore(4'b0000);
    step(); cur_date = 8'h15; cur_hour = 8'h12; cur_min = 8'h34; cur_sec = 8'h56;
    repeat (5) step();
    rd(4'd0, v); chk("R6", "no flag without tick", v[6], 1'b0);
    chk("R6", "no pin without tick", irq_pull, 1'b0);

    // R7: backup-supply enable
    cur_req = "R7";
    set_ignore(4'b1111);
    step(); on_battery = 1; repeat (2) step();
    wr(4'd6, 8'h80);
    tick_at(8'h01, 8'h00, 8'h00, 8'h00);
    @(negedge clk); chk("R7", "battery, AE only: pin", irq_pull, 1'b0);
    rd(4'd0, v); chk("R7", "battery, AE only: flag", v[6], 1'b1);
    wr(4'd6, 8'hC0);
    tick_at(8'h01, 8'h00, 8'h00, 8'h01);
    @(negedge clk); chk("R7", "battery, AE+ABE: pin", irq_pull, 1'b1);

    // R9: supply change clears enables, keeps flag
    cur_req = "R9";
    step(); on_battery = 0; repeat (2) step();
    @(negedge clk); chk("R9", "pin released on supply change", irq_pull, 1'b0);
    rd(4'd6, v); chk("R9", "enables cleared", v, 8'h00);
    rd(4'd0, v); chk("R9", "flag kept", v[6], 1'b1);

    // R8: access timing and set priority
    cur_req = "R8";
    wr(4'd6, 8'h80);
    tick_at(8'h02, 8'h00, 8'h00, 8'h00);
    step(); bus_en = 1; bus_we = 0; bus_addr = 4'd0;
    @(negedge clk); chk("R8", "pin in first access cycle", irq_pull, 1'b1);
    chk("R8", "flag first cycle", bus_rdata[6], 1'b1);
    @(negedge clk); chk("R8", "pin after access start", irq_pull, 1'b0);
    chk("R8", "flag held mid access", bus_rdata[6], 1'b1);
    step(); step(); bus_en = 0; tick_1hz = 1;
    step(); tick_1hz = 0;
    rd(4'd0, v); chk("R8", "tick at access end keeps flag", v[6], 1'b1);
    rd(4'd0, v); chk("R8", "flag cleared after access", v[6], 1'b0);

    // R10: frequency test output
    cur_req = "R10";
    wr(4'd6, 8'h01);
    step(); wdog_steer = 1; osc_run = 1; osc_tick = 1;
    count_toggles(330, t);
    chk("R10", "512 Hz toggles in 330 ticks", (t >= 9 && t <= 11), 1);
    step(); wdog_steer = 0;
    count_toggles(100, t); chk("R10", "off without steer or zero", t, 0);
    step(); wdog_zero = 1;
    count_toggles(100, t); chk("R10", "on with watchdog zero", (t >= 2), 1);
    wr(4'd6, 8'h81);
    count_toggles(100, t); chk("R10", "alarm enable suppresses test", t, 0);
    chk("R10", "pin released", irq_pull, 1'b0);
    wr(4'd6, 8'h01);
    step(); osc_run = 0;
    count_toggles(100, t); chk("R10", "off with oscillator stopped", t, 0);

    repeat (3) step();
    finish_run();
  end
endmodule